// File: doc/BRIEF.md
# System Clock Source Switcher

This block moves the system clock from the source it currently runs on to a newly requested one, chosen among up to eight incoming clocks. Software writes the wanted source index into a control word and sets a self-clearing switch bit. The controller looks at the synchronized ready flag of the target. If the target is not ready, the request is refused. Otherwise a glitch-free multiplexer turns the old clock off on its own falling edge, and only then turns the new one on. The current-source field changes once the new clock is confirmed running.

A second word holds a post-divider for the system clock, with ratio field value plus one. A change of the divider can be slewed: the effective divider walks one step at a time toward the new value, with a programmable interval between steps. Slowing down and speeding up each have their own enable. A busy flag stays high until the effective divider equals the programmed one. The divider works in the register clock domain. It produces a clock-enable pulse and reports the effective ratio.

Top module: `clksw_top`

## Requirements
- R1: After a synchronous active-low reset: both read words are zero (source 0 requested and current, switch bit clear, divider field 0, busy clear) and the effective divider is 1.
- R2: Writing the control word (address 0) with bit 0 set starts a switch to the source in bits 10:8. If that source is ready, bit 0 later clears, bits 14:12 read the new source, and `sys_clk_o` then runs at that source's frequency.
- R3: A switch to a source whose ready input is low is refused. Bit 0 still clears, bits 14:12 keep their old value and `sys_clk_o` keeps its old frequency.
- R4: The divider field is bits 23:20 of the slew word (address 1). Once settled, the effective divider is the field plus one and `div_ce_o` is high exactly one cycle in every (field+1) cycles.
- R5: Bit 0 of the slew word (busy) is high from the cycle after a divider write until the effective divider reaches field+1. While busy is low the effective divider does not change.
- R6: When the target divider is larger than the effective one and bit 1 is set, the effective divider rises by exactly one every 2^S clock cycles, where S is bits 10:8 of the slew word. With bit 1 clear it jumps to the target one cycle after the write.
- R7: When the target divider is smaller and bit 2 is set, the effective divider falls by exactly one every 2^S cycles. With bit 2 clear it jumps one cycle after the write.
- R8: Writes to the control word are ignored while bit 0 reads 1.
- R9: At most one source clock is gated onto `sys_clk_o` at any time. The old source is gated off before the new one is gated on.
- R10: Bits 14:12 of the control word and bit 0 of the slew word are read-only, so writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Register and controller clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| src_clk_i | input | NSRC | Candidate source clocks |
| src_rdy_i | input | NSRC | Per-source ready flags, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 selects the control word, 1 the slew word |
| wr_data_i | input | 32 | Write data |
| ctrl_o | output | 32 | Control word read value |
| slew_o | output | 32 | Slew word read value |
| eff_div_o | output | DIV_W+1 | Effective divider ratio now applied |
| div_ce_o | output | 1 | Divided clock-enable pulse |
| sys_clk_o | output | 1 | Multiplexed system clock |

## Verification
A stuck switch state shows at the ports in one of two ways. The switch bit stays set, or the current-source field disagrees with the measured period of `sys_clk_o`. Both are visible within a few source-clock periods after the request. A wrong step counter or effective divider changes how long busy stays high. It also changes the spacing of `div_ce_o` pulses, and the error appears on the first step interval after a write. The sweeps compare busy duration and pulse spacing against the arithmetic values for every divider setting and for several step settings, in both directions.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
    localparam int REG_W        = 32;
    // control word
    localparam int CTL_SWEN_BIT = 0;
    localparam int CTL_REQ_LSB  = 8;
    localparam int CTL_CUR_LSB  = 12;
    // slew word
    localparam int SLW_BUSY_BIT = 0;
    localparam int SLW_DOWN_BIT = 1;
    localparam int SLW_UP_BIT   = 2;
    localparam int SLW_STEP_LSB = 8;
    localparam int SLW_DIV_LSB  = 20;

    localparam logic ADDR_CTL = 1'b0;
    localparam logic ADDR_SLW = 1'b1;

    typedef enum logic {
        SW_IDLE = 1'b0,
        SW_WAIT = 1'b1
    } sw_state_e;
endpackage

// File: rtl/clksw_gmux.sv
module clksw_gmux #(
    parameter int NSRC  = 8,
    parameter int SEL_W = 3
) (
    input  logic             arst_ni,
    input  logic [NSRC-1:0]  src_clk_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [NSRC-1:0]  en_o,
    output logic             clk_o
);
    for (genvar k = 0; k < NSRC; k++) begin : g_leg
        logic others_on;
        logic want;
        logic arm_q;
        logic gate_q;

        // another leg still gating blocks this one from arming
        assign others_on = |(en_o & ~(NSRC'(1) << k));
        assign want      = (sel_i == SEL_W'(k)) && !others_on;

        always_ff @(posedge src_clk_i[k] or negedge arst_ni) begin
            if (!arst_ni) arm_q <= 1'b0;
            else          arm_q <= want;
        end

        // gate changes only while this source is low
        always_ff @(negedge src_clk_i[k] or negedge arst_ni) begin
            if (!arst_ni) gate_q <= 1'b0;
            else          gate_q <= arm_q;
        end

        assign en_o[k] = gate_q;
    end

    always_comb begin
        clk_o = |(src_clk_i & en_o);
    end
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
    import clksw_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int SEL_W  = 3,
    parameter int DIV_W  = 4,
    parameter int STEP_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [NSRC-1:0]   src_rdy_i,
    input  logic [NSRC-1:0]   mux_en_i,
    output logic [SEL_W-1:0]  sel_o,
    output logic [SEL_W-1:0]  req_src_o,
    output logic [SEL_W-1:0]  cur_src_o,
    output logic              swen_o,
    output logic              dn_en_o,
    output logic              up_en_o,
    output logic [STEP_W-1:0] step_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              div_wr_o
);
    typedef struct packed {
        sw_state_e        st;
        logic             swen;
        logic [SEL_W-1:0] req;
        logic [SEL_W-1:0] cur;
        logic [SEL_W-1:0] sel;
        logic [NSRC-1:0]  rdy_m;
        logic [NSRC-1:0]  rdy_s;
        logic [NSRC-1:0]  en_m;
        logic [NSRC-1:0]  en_s;
        logic             dn;
        logic             up;
        logic [STEP_W-1:0] step;
        logic [DIV_W-1:0] div;
    } ctl_t;

    ctl_t q, d;
    logic wr_ctl, wr_slw;
    logic unused_wr;

    assign wr_ctl    = wr_en_i && (wr_addr_i == ADDR_CTL);
    assign wr_slw    = wr_en_i && (wr_addr_i == ADDR_SLW);
    assign unused_wr = ^wr_data_i;

    always_comb begin
        d = q;
        d.rdy_m = src_rdy_i;
        d.rdy_s = q.rdy_m;
        d.en_m  = mux_en_i;
        d.en_s  = q.en_m;

        if (wr_ctl && !q.swen) begin
            d.req  = wr_data_i[CTL_REQ_LSB +: SEL_W];
            d.swen = wr_data_i[CTL_SWEN_BIT];
        end
        if (wr_slw) begin
            d.dn   = wr_data_i[SLW_DOWN_BIT];
            d.up   = wr_data_i[SLW_UP_BIT];
            d.step = wr_data_i[SLW_STEP_LSB +: STEP_W];
            d.div  = wr_data_i[SLW_DIV_LSB +: DIV_W];
        end

        unique case (q.st)
            SW_IDLE: begin
                if (q.swen) begin
                    if (!q.rdy_s[q.req] || (q.req == q.cur)) begin
                        d.swen = 1'b0;
                    end else begin
                        d.sel = q.req;
                        d.st  = SW_WAIT;
                    end
                end
            end
            SW_WAIT: begin
                if (q.en_s[q.req]) begin
                    d.cur  = q.req;
                    d.swen = 1'b0;
                    d.st   = SW_IDLE;
                end
            end
            default: d.st = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign sel_o     = q.sel;
    assign req_src_o = q.req;
    assign cur_src_o = q.cur;
    assign swen_o    = q.swen;
    assign dn_en_o   = q.dn;
    assign up_en_o   = q.up;
    assign step_o    = q.step;
    assign div_o     = q.div;
    assign div_wr_o  = wr_slw;
endmodule

// File: rtl/clksw_slew.sv
module clksw_slew #(
    parameter int DIV_W  = 4,
    parameter int STEP_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DIV_W-1:0]  tgt_i,
    input  logic              dn_en_i,
    input  logic              up_en_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              restart_i,
    output logic [DIV_W:0]    eff_o,
    output logic              busy_o,
    output logic              ce_o
);
    localparam int CNT_W = (1 << STEP_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] eff_m1;
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] dcnt;
    } slw_t;

    slw_t q, d;
    logic [CNT_W:0]   one_sh;
    logic [CNT_W-1:0] lim;
    logic             slower;
    logic             walk;

    assign one_sh = (CNT_W+1)'(1) << step_i;
    assign lim    = CNT_W'(one_sh - (CNT_W+1)'(1));
    assign busy_o = (q.eff_m1 != tgt_i);
    assign slower = (tgt_i > q.eff_m1);
    assign walk   = slower ? dn_en_i : up_en_i;
    assign ce_o   = (q.dcnt >= q.eff_m1);
    assign eff_o  = {1'b0, q.eff_m1} + 1'b1;

    always_comb begin
        d = q;
        d.dcnt = ce_o ? '0 : q.dcnt + 1'b1;
        if (restart_i) begin
            d.cnt = '0;
        end else if (busy_o) begin
            if (!walk) begin
                d.eff_m1 = tgt_i;
                d.cnt    = '0;
            end else if (q.cnt == lim) begin
                d.eff_m1 = slower ? q.eff_m1 + 1'b1 : q.eff_m1 - 1'b1;
                d.cnt    = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/clksw_top.sv
module clksw_top
    import clksw_pkg::*;
#(
    parameter  int NSRC   = 8,
    parameter  int DIV_W  = 4,
    parameter  int STEP_W = 3,
    localparam int SEL_W  = $clog2(NSRC),
    localparam int EFF_W  = DIV_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NSRC-1:0]  src_clk_i,
    input  logic [NSRC-1:0]  src_rdy_i,
    input  logic             wr_en_i,
    input  logic             wr_addr_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] ctrl_o,
    output logic [REG_W-1:0] slew_o,
    output logic [EFF_W-1:0] eff_div_o,
    output logic             div_ce_o,
    output logic             sys_clk_o
);
    logic [SEL_W-1:0]  sel, req_src, cur_src;
    logic              swen, dn_en, up_en, div_wr, busy;
    logic [STEP_W-1:0] step;
    logic [DIV_W-1:0]  div;
    logic [NSRC-1:0]   mux_en;
    logic              mux_rst_nq;

    // delayed copy of reset drives the source-domain flops asynchronously
    always_ff @(posedge clk_i) begin
        mux_rst_nq <= rst_ni;
    end

    clksw_ctrl #(
        .NSRC(NSRC), .SEL_W(SEL_W), .DIV_W(DIV_W), .STEP_W(STEP_W)
    ) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .src_rdy_i (src_rdy_i),
        .mux_en_i  (mux_en),
        .sel_o     (sel),
        .req_src_o (req_src),
        .cur_src_o (cur_src),
        .swen_o    (swen),
        .dn_en_o   (dn_en),
        .up_en_o   (up_en),
        .step_o    (step),
        .div_o     (div),
        .div_wr_o  (div_wr)
    );

    clksw_gmux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_gmux (
        .arst_ni   (mux_rst_nq),
        .src_clk_i (src_clk_i),
        .sel_i     (sel),
        .en_o      (mux_en),
        .clk_o     (sys_clk_o)
    );

    clksw_slew #(.DIV_W(DIV_W), .STEP_W(STEP_W)) u_slew (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tgt_i     (div),
        .dn_en_i   (dn_en),
        .up_en_i   (up_en),
        .step_i    (step),
        .restart_i (div_wr),
        .eff_o     (eff_div_o),
        .busy_o    (busy),
        .ce_o      (div_ce_o)
    );

    always_comb begin
        ctrl_o = '0;
        ctrl_o[CTL_SWEN_BIT]             = swen;
        ctrl_o[CTL_REQ_LSB +: SEL_W]     = req_src;
        ctrl_o[CTL_CUR_LSB +: SEL_W]     = cur_src;
        slew_o = '0;
        slew_o[SLW_BUSY_BIT]             = busy;
        slew_o[SLW_DOWN_BIT]             = dn_en;
        slew_o[SLW_UP_BIT]               = up_en;
        slew_o[SLW_STEP_LSB +: STEP_W]   = step;
        slew_o[SLW_DIV_LSB +: DIV_W]     = div;
    end
endmodule

// File: rtl/clksw_chk.sv
module clksw_chk
    import clksw_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int SEL_W = 3,
    parameter int EFF_W = 5
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [NSRC-1:0]  mux_en,
    input logic [REG_W-1:0] ctrl_o,
    input logic [REG_W-1:0] slew_o,
    input logic [EFF_W-1:0] eff_div_o
);
    AST_MUX_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(mux_en)); // R9

    AST_CUR_NEEDS_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ctrl_o[CTL_CUR_LSB +: SEL_W]) |-> $past(ctrl_o[CTL_SWEN_BIT]) && !ctrl_o[CTL_SWEN_BIT]); // R2

    AST_EFF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eff_div_o >= EFF_W'(1)) && (eff_div_o <= EFF_W'(1 << (EFF_W - 1)))); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(slew_o[SLW_BUSY_BIT]) |-> $stable(eff_div_o)); // R5

    AST_DOWN_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(slew_o[SLW_DOWN_BIT]) && (eff_div_o > $past(eff_div_o)))
        |-> (eff_div_o == $past(eff_div_o) + 1'b1)); // R6

    AST_UP_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(slew_o[SLW_UP_BIT]) && (eff_div_o < $past(eff_div_o)))
        |-> (eff_div_o + 1'b1 == $past(eff_div_o))); // R7
endmodule

bind clksw_top clksw_chk #(.NSRC(NSRC), .SEL_W(SEL_W), .EFF_W(EFF_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mux_en    (mux_en),
    .ctrl_o    (ctrl_o),
    .slew_o    (slew_o),
    .eff_div_o (eff_div_o)
);

// File: tb/clksw_top_test.sv
`timescale 1ns/1ps
module clksw_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_clk;
    logic [7:0]  src_rdy = 8'b0011_1111;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ctrl_rd, slew_rd;
    logic [4:0]  eff;
    logic        ce, sys_clk;
    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    for (genvar g = 0; g < 8; g++) begin : g_src
        initial begin
            src_clk[g] = 1'b0;
            if (g != 7) forever #(3 + g) src_clk[g] = ~src_clk[g];
        end
    end

    clksw_top uut (
        .clk_i(clk), .rst_ni(rst_n), .src_clk_i(src_clk), .src_rdy_i(src_rdy),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .ctrl_o(ctrl_rd), .slew_o(slew_rd), .eff_div_o(eff),
        .div_ce_o(ce), .sys_clk_o(sys_clk)
    );

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(bit addr, logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_swen();
        int n = 0;
        while (ctrl_rd[0] && n < 4000) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic int period_of(int src);
        return 2 * (3 + src);
    endfunction

    task automatic sys_period(output int p);
        realtime t0;
        @(posedge sys_clk);
        t0 = $realtime;
        @(posedge sys_clk);
        p = $rtoi($realtime - t0 + 0.5);
        @(negedge clk);
    endtask

    task automatic do_switch(int src, string req, int exp_cur);
        int p;
        wr(1'b0, (32'(src) << 8) | 32'h1);
        wait_swen();
        check({req, " swen cleared"}, int'(ctrl_rd[0]), 0);
        check({req, " current source"}, int'(ctrl_rd[14:12]), exp_cur);
        repeat (4) @(negedge clk);
        sys_period(p);
        check({req, " R9 output period"}, p, period_of(exp_cur));
    endtask

    // returns busy samples counted from the cycle after the write
    task automatic slew_write(int dv, int s, bit dn, bit up, output int n);
        wr(1'b1, (32'(dv) << 20) | (32'(s) << 8) | (32'(up) << 2) | (32'(dn) << 1));
        n = 0;
        while (slew_rd[0] && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        int p;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ctrl word", int'(ctrl_rd), 0);
        check("R1 slew word", int'(slew_rd), 0);
        check("R1 effective divider", int'(eff), 1);
        repeat (30) @(negedge clk);
        sys_period(p);
        check("R9 source 0 period", p, period_of(0));

        do_switch(3, "R2", 3);
        do_switch(6, "R3 not ready", 3);
        do_switch(7, "R3 stopped", 3);

        // R8: second write while switching is ignored
        wr(1'b0, (32'd1 << 8) | 32'h1);
        wr(1'b0, (32'd2 << 8) | 32'h1);
        check("R8 request field kept", int'(ctrl_rd[10:8]), 1);
        wait_swen();
        check("R8 switch landed on first request", int'(ctrl_rd[14:12]), 1);

        do_switch(5, "R2", 5);
        do_switch(5, "R2 same source", 5);
        do_switch(0, "R2", 0);
        do_switch(4, "R2", 4);

        // R10 read-only fields
        wr(1'b0, (32'd7 << 12) | (32'd4 << 8));
        check("R10 current field not writable", int'(ctrl_rd[14:12]), 4);
        sys_period(p);
        check("R10 output period unchanged", p, period_of(4));
        wr(1'b1, 32'h1);
        check("R10 busy not writable", int'(slew_rd[0]), 0);
        check("R10 divider unchanged", int'(eff), 1);

        // R4 ratio sweep, no slewing
        for (int k = 0; k < 16; k++) begin
            slew_write(k, 0, 1'b0, 1'b0, n);
            check("R7/R6 jump busy cycles", n, (k == 0) ? 0 : 1);
            repeat (40) @(negedge clk);
            check("R4 effective divider", int'(eff), k + 1);
            while (!ce) @(negedge clk);
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!ce && n < 100);
            check("R4 enable spacing", n, k + 1);
        end
        slew_write(0, 0, 1'b0, 1'b0, n);

        // R5/R6/R7 slewed steps
        for (int s = 0; s < 3; s++) begin
            for (int t = 3; t <= 15; t += 6) begin
                slew_write(t, s, 1'b1, 1'b0, n);
                check("R6 slow-down busy cycles", n, t * (1 << s));
                check("R5 settled divider", int'(eff), t + 1);
                slew_write(0, s, 1'b0, 1'b1, n);
                check("R7 speed-up busy cycles", n, t * (1 << s));
                check("R5 settled divider", int'(eff), 1);
                slew_write(t, s, 1'b0, 1'b1, n);
                check("R6 jump when down slew off", n, 1);
                slew_write(0, s, 1'b1, 1'b0, n);
                check("R7 jump when up slew off", n, 1);
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule